// File: doc/BRIEF.md
# Run-Time Configurable Asynchronous Frame Transmitter

This block turns bytes from a transmit buffer into asynchronous serial frames on one output line. The buffer shows its head byte with a valid flag. The transmitter pops a byte only when it can start that byte's frame at once. It does not count the bit time itself. It follows an enable pulse that arrives at sixteen times the bit rate, so one divisor elsewhere in the chip sets the rate.

The frame shape is chosen at run time. The settings are the data length (5 to 8 bits), whether a parity bit is sent, odd or even parity, a constant ("sticky") parity bit, and one or two stop bits. The block takes a copy of the settings when a frame begins, so software may rewrite them while a frame is on the line. A break input drives the line low at once and for as long as it is held. Under a break the frame keeps its own timing internally. Busy and empty outputs let the surrounding logic tell when the line has gone quiet.

Top module: `uart_frame_tx`

## Requirements
- R1: Out of reset, and at any time no frame is being sent and no break is held, `tx_line` is high.
- R2: A frame is a low start bit, then the data bits least significant first, then the optional parity bit, then one or two high stop bits.
- R3: `cfg_len` selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8. Only that many low-order bits of the byte are sent, and the next bit slot after them holds the parity or stop bit.
- R4: With `cfg_par_en` = 1 and `cfg_par_stick` = 0, a parity bit follows the data. `cfg_par_odd` = 0 makes the count of ones over the sent data and parity even. `cfg_par_odd` = 1 makes that count odd. Data bits that are not sent do not count.
- R5: With `cfg_par_en` = 1 and `cfg_par_stick` = 1, the parity bit is a constant equal to `cfg_par_odd`, whatever the data.
- R6: `cfg_stop2` = 1 sends two stop bits. `cfg_stop2` = 0 sends one.
- R7: Every bit of a frame lasts exactly 16 `baud_tick` pulses. A tick that falls in the cycle the byte is popped does not count.
- R8: While `cfg_break` is high, `tx_line` is low from the next clock on. This holds even during a frame. The frame's timing continues, and the frame finishes normally.
- R9: The configuration inputs are captured in the cycle the byte is popped. A change during a frame only affects later frames.
- R10: `fifo_pop` is high only when `fifo_valid` is high and the transmitter is idle or is ending the last stop bit. A byte that is waiting when a frame ends starts its start bit with no idle time between the frames.
- R11: `tx_busy` is high while a frame is being shifted. `tx_empty` is high only when `fifo_valid` is low and no frame is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| fifo_data | input | 8 | Head byte of the transmit buffer |
| fifo_valid | input | 1 | Buffer holds at least one byte |
| fifo_pop | output | 1 | Takes the head byte in this cycle |
| cfg_len | input | 2 | Data length code (5 + value bits) |
| cfg_par_en | input | 1 | Send a parity bit |
| cfg_par_odd | input | 1 | Odd parity (or sticky value 1) |
| cfg_par_stick | input | 1 | Constant parity bit |
| cfg_stop2 | input | 1 | Two stop bits |
| cfg_break | input | 1 | Force the line low |
| tx_line | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | Frame in progress |
| tx_empty | output | 1 | Buffer empty and no frame in progress |

## Verification
The hardest case to reach is a configuration change that lands between two frames sent back to back. The rewrite must come after the first pop and before the second. The second frame must pick up the new shape with no idle gap, and the first must keep the old one. The stimulus queues two bytes together and waits for `tx_busy` to rise. It then rewrites the configuration while the first frame is still on the line. The monitor counts baud ticks from one start edge to the next, so the gap check also measures the length of each stop and data field. A break is also applied in the middle of a frame, and the line is checked across several bit boundaries.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int LEN_W = 2;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             par_en;
    logic             par_odd;
    logic             par_stick;
    logic             stop2;
  } tx_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_e;

endpackage

// File: rtl/tx_tick_timer.sv
module tx_tick_timer #(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  input  logic tick,
  output logic bit_end
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (run && tick) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign bit_end = run && tick && (cnt_q == LAST);
endmodule

// File: rtl/tx_parity_gen.sv
module tx_parity_gen
  import uart_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5
) (
  input  logic [DATA_W-1:0] data,
  input  logic [LEN_W-1:0]  len,
  input  logic              par_odd,
  input  logic              par_stick,
  output logic              par_bit
);
  logic [DATA_W-1:0] mask;
  logic              ones_odd;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    if (g < MIN_BITS) begin : g_fixed
      assign mask[g] = 1'b1;
    end else begin : g_sel
      assign mask[g] = ({1'b0, len} > (LEN_W + 1)'(g - MIN_BITS));
    end
  end

  assign ones_odd = ^(data & mask);
  assign par_bit  = par_stick ? par_odd : (ones_odd ^ par_odd);
endmodule

// File: rtl/tx_frame_fsm.sv
module tx_frame_fsm
  import uart_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_end,
  input  logic              fifo_valid,
  input  logic [DATA_W-1:0] fifo_data,
  input  tx_cfg_t           cfg_in,
  input  logic              par_in,
  output logic              load,
  output logic              busy,
  output logic              level_d
);
  localparam int IDX_W = $clog2(DATA_W);

  tx_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  tx_cfg_t           cfg_q, cfg_d;
  logic              par_q, par_d;
  logic              level_q;
  logic              last_data, stop_more, finishing, ready;

  assign last_data = (int'(idx_q) == MIN_BITS - 1 + int'(cfg_q.len));
  assign stop_more = cfg_q.stop2 && (idx_q == '0);
  assign finishing = (state_q == ST_STOP) && bit_end && !stop_more;
  assign ready     = (state_q == ST_IDLE) || finishing;
  assign load      = ready && fifo_valid;
  assign busy      = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    cfg_d   = cfg_q;
    par_d   = par_q;
    level_d = level_q;
    case (state_q)
      ST_IDLE: level_d = 1'b1;
      ST_START: if (bit_end) begin
        state_d = ST_DATA;
        idx_d   = '0;
        level_d = sh_q[0];
      end
      ST_DATA: if (bit_end) begin
        if (last_data) begin
          idx_d = '0;
          if (cfg_q.par_en) begin
            state_d = ST_PARITY;
            level_d = par_q;
          end else begin
            state_d = ST_STOP;
            level_d = 1'b1;
          end
        end else begin
          idx_d   = idx_q + 1'b1;
          sh_d    = sh_q >> 1;
          level_d = sh_q[1];
        end
      end
      ST_PARITY: if (bit_end) begin
        state_d = ST_STOP;
        idx_d   = '0;
        level_d = 1'b1;
      end
      ST_STOP: if (bit_end) begin
        if (stop_more) begin
          idx_d = idx_q + 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
        level_d = 1'b1;
      end
      default: begin
        state_d = ST_IDLE;
        level_d = 1'b1;
      end
    endcase
    if (load) begin
      state_d = ST_START;
      idx_d   = '0;
      sh_d    = fifo_data;
      cfg_d   = cfg_in;
      par_d   = par_in;
      level_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sh_q    <= '0;
      cfg_q   <= '0;
      par_q   <= 1'b0;
      level_q <= 1'b1;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      cfg_q   <= cfg_d;
      par_q   <= par_d;
      level_q <= level_d;
    end
  end
endmodule

// File: rtl/tx_line_reg.sv
module tx_line_reg (
  input  logic clk,
  input  logic rst,
  input  logic brk,
  input  logic level_d,
  output logic line_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b1;
    end else begin
      line_q <= brk ? 1'b0 : level_d;
    end
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MIN_BITS   = 5,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_valid,
  output logic              fifo_pop,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_par_stick,
  input  logic              cfg_stop2,
  input  logic              cfg_break,
  output logic              tx_line,
  output logic              tx_busy,
  output logic              tx_empty
);
  tx_cfg_t cfg_in;
  logic    par_in, bit_end, load, level_d;

  assign cfg_in = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd,
                    par_stick: cfg_par_stick, stop2: cfg_stop2};

  tx_parity_gen #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS)) u_par (
    .data(fifo_data), .len(cfg_len), .par_odd(cfg_par_odd),
    .par_stick(cfg_par_stick), .par_bit(par_in)
  );

  tx_tick_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
    .clk(clk), .rst(rst), .run(tx_busy), .clear(load),
    .tick(baud_tick), .bit_end(bit_end)
  );

  tx_frame_fsm #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS)) u_fsm (
    .clk(clk), .rst(rst), .bit_end(bit_end), .fifo_valid(fifo_valid),
    .fifo_data(fifo_data), .cfg_in(cfg_in), .par_in(par_in),
    .load(load), .busy(tx_busy), .level_d(level_d)
  );

  tx_line_reg u_line (
    .clk(clk), .rst(rst), .brk(cfg_break), .level_d(level_d), .line_q(tx_line)
  );

  assign fifo_pop = load;
  assign tx_empty = !tx_busy && !fifo_valid;
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rst,
  input logic baud_tick,
  input logic fifo_valid,
  input logic fifo_pop,
  input logic cfg_break,
  input logic tx_line,
  input logic tx_busy
);
  // R10: a pop needs a byte on offer
  p_pop_needs_valid_r10: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> fifo_valid);

  // R10: a pop always leaves a frame running
  p_pop_starts_frame_r10: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> tx_busy);

  // R8: break pulls the line low on the next clock
  p_break_low_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_break |=> !tx_line);

  // R1: idle line is high unless a break was applied
  p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
    (!tx_busy && !$past(cfg_break)) |-> tx_line);

  // R2: the first bit after leaving idle is the low start bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_busy) |-> !tx_line);

  // R7: the line moves only on a tick, a pop or a break change
  p_move_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(baud_tick) && !$past(fifo_pop) && !$past(cfg_break)
     && !$past(cfg_break, 2)) |-> $stable(tx_line));
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk(clk), .rst(rst), .baud_tick(baud_tick), .fifo_valid(fifo_valid),
  .fifo_pop(fifo_pop), .cfg_break(cfg_break), .tx_line(tx_line),
  .tx_busy(tx_busy)
);

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;
  import uart_tx_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic [7:0] fifo_data = 8'h00;
  logic       fifo_valid = 1'b0;
  logic       fifo_pop;
  tx_cfg_t    cfg = '{len: 2'd3, par_en: 1'b0, par_odd: 1'b0, par_stick: 1'b0, stop2: 1'b0};
  logic       cfg_break = 1'b0;
  logic       tx_line, tx_busy, tx_empty;

  always #4 clk = ~clk;

  uart_frame_tx dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .fifo_data(fifo_data),
    .fifo_valid(fifo_valid), .fifo_pop(fifo_pop), .cfg_len(cfg.len),
    .cfg_par_en(cfg.par_en), .cfg_par_odd(cfg.par_odd),
    .cfg_par_stick(cfg.par_stick), .cfg_stop2(cfg.stop2),
    .cfg_break(cfg_break), .tx_line(tx_line), .tx_busy(tx_busy),
    .tx_empty(tx_empty)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // baud enable: one pulse every third clock
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv == 2) ? 0 : tdiv + 1;
    baud_tick = (tdiv == 0);
  end

  int tick_total = 0;
  always @(posedge clk) if (baud_tick) tick_total <= tick_total + 1;

  // buffer model
  logic [7:0] fq[$];
  bit pend = 0;
  int pop_cnt = 0;
  always @(negedge clk) begin
    if (pend) begin
      void'(fq.pop_front());
      pop_cnt++;
    end
    fifo_valid = (fq.size() != 0);
    fifo_data  = fifo_valid ? fq[0] : 8'h00;
    #1 pend = fifo_pop;
  end

  typedef struct {
    logic [15:0] bits;
    int          n;
    bit          gap;
    string       req;
  } exp_t;
  exp_t eq[$];

  function automatic exp_t build(input logic [7:0] d, input tx_cfg_t c,
                                 input bit gap, input string req);
    exp_t e;
    int nb = 5 + int'(c.len);
    int k = 1;
    int ones = 0;
    e.bits = '0;
    e.bits[0] = 1'b0;
    for (int i = 0; i < nb; i++) begin
      e.bits[k] = d[i];
      ones += int'(d[i]);
      k++;
    end
    if (c.par_en) begin
      e.bits[k] = c.par_stick ? c.par_odd : (((ones % 2) == 1) ^ c.par_odd);
      k++;
    end
    e.bits[k] = 1'b1;
    k++;
    if (c.stop2) begin
      e.bits[k] = 1'b1;
      k++;
    end
    e.n = k;
    e.gap = gap;
    e.req = req;
    return e;
  endfunction

  task automatic send(input logic [7:0] d, input tx_cfg_t c, input bit gap,
                      input string req);
    fq.push_back(d);
    eq.push_back(build(d, c, gap, req));
  endtask

  // scoreboard monitor
  bit mon_en = 1;
  int frames = 0;
  int last_st = 0;
  int last_n = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && !rst && !tx_line && !cfg_break) begin
        int st;
        exp_t e;
        logic [15:0] got;
        st = tick_total;
        got = '0;
        if (eq.size() == 0) begin
          check(0, "R10", "frame with no byte queued", 0, 1);
          while (!tx_empty) @(negedge clk);
        end else begin
          e = eq.pop_front();
          frames++;
          if (e.gap)
            check(st - last_st == 16 * last_n, "R7", "ticks between back-to-back starts",
                  st - last_st, 16 * last_n);
          for (int i = 0; i < e.n; i++) begin
            while (tick_total != st + 16 * i + 8) @(negedge clk);
            got[i] = tx_line;
            if (i == 0) check(pop_cnt == frames, "R10", "pops per started frame", pop_cnt, frames);
          end
          check(got == e.bits, e.req, "frame bits (LSB = start)", int'(got), int'(e.bits));
          last_st = st;
          last_n = e.n;
        end
      end
    end
  end

  task automatic wait_idle();
    while (eq.size() != 0) @(posedge clk);
    while (!tx_empty) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  tx_cfg_t c8n1, ca, cb;
  int lows;

  initial begin
    c8n1 = '{len: 2'd3, par_en: 1'b0, par_odd: 1'b0, par_stick: 1'b0, stop2: 1'b0};
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1, R11: reset state
    check(tx_line == 1'b1, "R1", "line after reset", tx_line, 1);
    check(tx_busy == 1'b0, "R11", "busy after reset", tx_busy, 0);
    check(tx_empty == 1'b1, "R11", "empty after reset", tx_empty, 1);
    check(fifo_pop == 1'b0, "R10", "pop with empty buffer", fifo_pop, 0);

    // R2 / R10: two 8-bit frames back to back
    @(posedge clk); #1;
    cfg = c8n1;
    send(8'hA5, cfg, 0, "R2");
    send(8'h3C, cfg, 1, "R2");
    wait_idle();

    // R3: shorter lengths, the first unsent bit is zero
    cfg = '{len: 2'd0, par_en: 1'b0, par_odd: 1'b0, par_stick: 1'b0, stop2: 1'b0};
    send(8'hD5, cfg, 0, "R3"); wait_idle();
    cfg.len = 2'd1;
    send(8'hB5, cfg, 0, "R3"); wait_idle();
    cfg.len = 2'd2;
    send(8'h75, cfg, 0, "R3"); wait_idle();

    // R4: even and odd parity, incl. a length that masks set bits
    cfg = '{len: 2'd3, par_en: 1'b1, par_odd: 1'b0, par_stick: 1'b0, stop2: 1'b0};
    send(8'h01, cfg, 0, "R4");
    send(8'h03, cfg, 1, "R4"); wait_idle();
    cfg.par_odd = 1'b1;
    send(8'h01, cfg, 0, "R4");
    send(8'h03, cfg, 1, "R4"); wait_idle();
    cfg.len = 2'd1;
    send(8'h41, cfg, 0, "R4"); wait_idle();

    // R5: sticky parity disagrees with the computed one
    cfg = '{len: 2'd3, par_en: 1'b1, par_odd: 1'b1, par_stick: 1'b1, stop2: 1'b0};
    send(8'h07, cfg, 0, "R5"); wait_idle();
    cfg.par_odd = 1'b0;
    send(8'h07, cfg, 0, "R5"); wait_idle();

    // R6: two stop bits, length proven by the start-to-start gap
    cfg = '{len: 2'd3, par_en: 1'b0, par_odd: 1'b0, par_stick: 1'b0, stop2: 1'b1};
    send(8'h55, cfg, 0, "R6");
    send(8'hAA, cfg, 1, "R6"); wait_idle();
    cfg = '{len: 2'd0, par_en: 1'b1, par_odd: 1'b0, par_stick: 1'b0, stop2: 1'b1};
    send(8'h1F, cfg, 0, "R6");
    send(8'h0E, cfg, 1, "R6"); wait_idle();

    // R7 / R10: burst of four 7-bit odd-parity frames
    cfg = '{len: 2'd2, par_en: 1'b1, par_odd: 1'b1, par_stick: 1'b0, stop2: 1'b0};
    for (int i = 0; i < 4; i++) send(8'(8'h11 * (i + 3)), cfg, i != 0, "R7");
    wait_idle();

    // R9: configuration rewritten during the first of two queued frames
    ca = c8n1;
    cb = '{len: 2'd1, par_en: 1'b1, par_odd: 1'b0, par_stick: 1'b0, stop2: 1'b1};
    cfg = ca;
    send(8'h96, ca, 0, "R9");
    send(8'h5A, cb, 1, "R9");
    while (!tx_busy) @(posedge clk);
    #1 cfg = cb;
    // R11: frame running with nothing left queued
    while (!(tx_busy && fq.size() == 0)) @(negedge clk);
    @(negedge clk);
    check(tx_busy == 1'b1, "R11", "busy during last frame", tx_busy, 1);
    check(tx_empty == 1'b0, "R11", "empty during last frame", tx_empty, 0);
    wait_idle();
    check(tx_busy == 1'b0, "R11", "busy after last frame", tx_busy, 0);
    check(tx_empty == 1'b1, "R11", "empty after last frame", tx_empty, 1);
    check(tx_line == 1'b1, "R1", "line idle after frames", tx_line, 1);

    // R8: break while idle
    mon_en = 0;
    cfg_break = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tx_line == 1'b0, "R8", "line under idle break", tx_line, 0);
    @(posedge clk); #1 cfg_break = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(tx_line == 1'b1, "R8", "line after break released", tx_line, 1);

    // R8: break across bit boundaries of an all-ones frame
    @(posedge clk); #1;
    cfg = c8n1;
    fq.push_back(8'hFF);
    while (!tx_busy) @(posedge clk);
    repeat (60) @(posedge clk);
    #1 cfg_break = 1'b1;
    @(posedge clk);
    lows = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tx_line == 1'b0) lows++;
    end
    check(lows == 200, "R8", "cycles low under break in frame", lows, 200);
    @(posedge clk); #1 cfg_break = 1'b0;
    while (!tx_empty) @(posedge clk);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(tx_line == 1'b1, "R8", "line after frame under break", tx_line, 1);
    check(tx_busy == 1'b0, "R8", "frame finished under break", tx_busy, 0);

    summary();
  end
endmodule